// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic read and write an external asynchronous static RAM of 32K bytes. The system side offers a single request at a time: the requester raises `req_valid` with a direction flag, an address and, for stores, a byte. The controller answers with a one-clock `rsp_valid` pulse, carrying the fetched byte on loads. While an access is in flight `req_ready` is low and requests are not taken.

On the memory side the controller drives the address, three active-low strobes (select, output enable, write enable) and a split data bus with a separate output-enable signal. Every phase length is a cycle count. It is derived at elaboration from nanosecond timing parameters and the clock period by rounding up, with a floor of one cycle. A store asserts write enable only while the chip is already selected and ends the pulse on write enable, with address and data held one more cycle. A load samples the bus at the end of the counted access time, then waits out the memory's output-disable time before the controller may drive the bus again.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low and after it, until a request arrives: `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: During a store, `mem_we_n` is low for exactly WP cycles, the largest of the rounded-up write pulse width, data setup and address-to-write-end times (2 cycles at a 5 ns clock). Throughout that time `mem_ce_n` is 0, `mem_oe_n` is 1 and `mem_dq_oe` is 1.
- R3: A store is ended by `mem_we_n` rising while `mem_ce_n` stays 0 and `mem_dq_oe`, `mem_addr` and `mem_dq_out` are held. After that hold phase (1 cycle at the default timing) `mem_ce_n` returns to 1 and `mem_dq_oe` to 0.
- R4: During a load, `mem_ce_n` and `mem_oe_n` are 0, `mem_we_n` is 1 and `mem_dq_oe` is 0 for exactly RD cycles, the larger of the rounded-up address and output-enable access times (3 cycles at 5 ns). `mem_dq_in` is sampled at the end of the last of them and returned on `rsp_rdata`.
- R5: After `mem_oe_n` goes high, `mem_dq_oe` stays 0 for at least HZ cycles, the rounded-up output-disable time (2 cycles at 5 ns).
- R6: `rsp_valid` is high for exactly one clock per accepted request, in the first idle cycle. `rsp_rdata` keeps the last loaded byte until the next load completes.
- R7: `req_valid` has no effect while `req_ready` is 0: no access is started, no response is produced and memory contents are unchanged.
- R8: Measured from the accepting clock edge, a store takes 1 + WP + HOLD edges to its response, where HOLD = max(1, WC - 1 - WP) and WC is the rounded-up write cycle time. A load takes RD + HZ edges (4 and 5 at the defaults).
- R9: `mem_addr` is constant for as long as `mem_ce_n` stays 0.
- R10: The controller never drives the bus while the memory may: `mem_dq_oe` is 0 whenever `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to store |
| req_ready | output | 1 | Controller idle, request taken at the next edge |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Last loaded byte |
| mem_addr | output | 15 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data seen on the memory bus |
| mem_dq_oe | output | 1 | Controller drives the bus when 1 |

## Verification
The properties assume a requester that only relies on `req_valid` being sampled while `req_ready` is high, and a memory that obeys its own strobes: it drives the bus only under a load combination and stores on the rising edge that ends a store. The bench memory model behaves exactly that way and flags any cycle where both sides drive. The driver issues a request only after seeing `req_ready`. It raises `req_valid` during a busy access on purpose, but only for the R7 case, and then withdraws it before the controller is idle again, so the ignored request never overlaps an idle cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WSETUP  = 3'd1,
        ST_WPULSE  = 3'd2,
        ST_WHOLD   = 3'd3,
        ST_RACCESS = 3'd4,
        ST_RTURN   = 3'd5
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    // nanoseconds to clock cycles, rounded up, never below one cycle
    function automatic int ns2cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q > CW'(1)) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CW'(1);
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q <= CW'(1));
endmodule

// File: rtl/asram_strobe_dec.sv
module asram_strobe_dec
    import asram_pkg::*;
(
    input  phase_e  phase,
    output strobe_t strb
);
    always_comb begin
        strb = STROBE_QUIET;
        unique case (phase)
            ST_WSETUP: begin
                strb.ce_n = 1'b0;
            end
            ST_WPULSE: begin
                strb.ce_n  = 1'b0;
                strb.we_n  = 1'b0;
                strb.dq_oe = 1'b1;
            end
            ST_WHOLD: begin
                strb.ce_n  = 1'b0;
                strb.dq_oe = 1'b1;
            end
            ST_RACCESS: begin
                strb.ce_n = 1'b0;
                strb.oe_n = 1'b0;
            end
            default: strb = STROBE_QUIET;
        endcase
    end
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] data_d, data_q;

    always_comb begin
        data_d = en ? din : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout = data_q;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 5,
    parameter int T_WC_NS       = 15,
    parameter int T_WP_NS       = 10,
    parameter int T_AW_NS       = 10,
    parameter int T_SD_NS       = 9,
    parameter int T_AA_NS       = 15,
    parameter int T_DOE_NS      = 6,
    parameter int T_HZOE_NS     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    // derived phase lengths in clock cycles
    localparam int SETUP_CYC = 1;
    localparam int WP_CYC    = imax(imax(ns2cyc(T_WP_NS, CLK_PERIOD_NS),
                                         ns2cyc(T_SD_NS, CLK_PERIOD_NS)),
                                    ns2cyc(T_AW_NS, CLK_PERIOD_NS));
    localparam int WC_CYC    = ns2cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int HOLD_CYC  = imax(1, WC_CYC - SETUP_CYC - WP_CYC);
    localparam int RD_CYC    = imax(ns2cyc(T_AA_NS, CLK_PERIOD_NS),
                                    ns2cyc(T_DOE_NS, CLK_PERIOD_NS));
    localparam int HZ_CYC    = ns2cyc(T_HZOE_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC   = imax(imax(WP_CYC, HOLD_CYC), imax(RD_CYC, HZ_CYC));
    localparam int CW        = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              done;
    } ctrl_t;

    ctrl_t         cur_q, nxt_d;
    strobe_t       strb_d, strb_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_last;
    logic          cap_en;
    phase_e        nxt_phase;

    asram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    asram_rd_capture #(.DW(DATA_W)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cap_en),
        .din   (mem_dq_in),
        .dout  (rsp_rdata)
    );

    assign nxt_phase = nxt_d.phase;

    asram_strobe_dec u_dec (
        .phase (nxt_phase),
        .strb  (strb_d)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        cap_en     = 1'b0;
        unique case (cur_q.phase)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.addr  = req_addr;
                    nxt_d.wdata = req_wdata;
                    tmr_load    = 1'b1;
                    if (req_write) begin
                        nxt_d.phase = ST_WSETUP;
                        tmr_val     = CW'(SETUP_CYC);
                    end else begin
                        nxt_d.phase = ST_RACCESS;
                        tmr_val     = CW'(RD_CYC);
                    end
                end
            end
            ST_WSETUP: begin
                if (tmr_last) begin
                    nxt_d.phase = ST_WPULSE;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(WP_CYC);
                end
            end
            ST_WPULSE: begin
                if (tmr_last) begin
                    nxt_d.phase = ST_WHOLD;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(HOLD_CYC);
                end
            end
            ST_WHOLD: begin
                if (tmr_last) begin
                    nxt_d.phase = ST_IDLE;
                    nxt_d.done  = 1'b1;
                end
            end
            ST_RACCESS: begin
                if (tmr_last) begin
                    cap_en      = 1'b1;
                    nxt_d.phase = ST_RTURN;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(HZ_CYC);
                end
            end
            ST_RTURN: begin
                if (tmr_last) begin
                    nxt_d.phase = ST_IDLE;
                    nxt_d.done  = 1'b1;
                end
            end
            default: begin
                nxt_d.phase = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.phase <= ST_IDLE;
            cur_q.addr  <= '0;
            cur_q.wdata <= '0;
            cur_q.done  <= 1'b0;
            strb_q      <= STROBE_QUIET;
        end else begin
            cur_q  <= nxt_d;
            strb_q <= strb_d;
        end
    end

    assign req_ready  = (cur_q.phase == ST_IDLE);
    assign rsp_valid  = cur_q.done;
    assign mem_addr   = cur_q.addr;
    assign mem_dq_out = cur_q.wdata;
    assign mem_ce_n   = strb_q.ce_n;
    assign mem_oe_n   = strb_q.oe_n;
    assign mem_we_n   = strb_q.we_n;
    assign mem_dq_oe  = strb_q.dq_oe;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int WP_CYC = 2,
    parameter int HZ_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    logic [7:0] we_low_q;
    logic [7:0] oe_high_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_q  <= 8'd0;
            oe_high_q <= 8'hFF;
        end else begin
            if (!mem_we_n) we_low_q <= (we_low_q == 8'hFF) ? we_low_q : we_low_q + 8'd1;
            else           we_low_q <= 8'd0;
            if (mem_oe_n)  oe_high_q <= (oe_high_q == 8'hFF) ? oe_high_q : oe_high_q + 8'd1;
            else           oe_high_q <= 8'd0;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    a_r2_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    a_r2_min_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_q >= 8'(WP_CYC)));

    a_r3_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

    a_r4_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_high_q >= 8'(HZ_CYC)));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WP_CYC (WP_CYC),
    .HZ_CYC (HZ_CYC)
) u_chk (.*);

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;
    localparam int PER    = 5;
    localparam int E_WP   = 2;   // ceil of 10, 9, 10 ns over 5 ns
    localparam int E_HOLD = 1;   // max(1, ceil(15/5) - 1 - 2)
    localparam int E_RD   = 3;   // ceil(15/5) vs ceil(6/5)
    localparam int E_HZ   = 2;   // ceil(7/5)
    localparam int E_WLAT = 1 + 1 + E_WP + E_HOLD;
    localparam int E_RLAT = 1 + E_RD + E_HZ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    asram_ctrl i_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // behavioural memory: drives only under a load combination, stores on the ending edge
    logic [7:0] ram [0:1023];
    logic [7:0] shadow [0:1023];
    wire model_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
    wire wr_end    = mem_ce_n | mem_we_n;
    assign mem_dq_in = model_drv ? ram[mem_addr[9:0]] : 8'hEE;
    always @(posedge wr_end) if (rst_n) ram[mem_addr[9:0]] <= mem_dq_out;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    typedef struct { bit rd; logic [7:0] d; } exp_t;
    exp_t sb[$];

    // monitor: strobe timing and scoreboard
    int  we_cnt = 0, oe_cnt = 0, oe_hi = 99;
    bit  we_prev = 1, oe_prev = 1, dq_prev = 0, rsp_prev = 0, after_hold = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(model_drv && mem_dq_oe), "R10 both sides drive", mem_dq_oe, 0);
            if (after_hold) begin
                chk(mem_ce_n && !mem_dq_oe, "R3 release after hold", {mem_ce_n, mem_dq_oe}, 2'b10);
                after_hold = 0;
            end
            if (!mem_we_n) begin
                we_cnt++;
                chk(!mem_ce_n && mem_oe_n && mem_dq_oe, "R2 strobes during pulse",
                    {mem_ce_n, mem_oe_n, mem_dq_oe}, 3'b011);
            end else if (!we_prev) begin
                chk(we_cnt == E_WP, "R2 write pulse length", we_cnt, E_WP);
                chk(!mem_ce_n && mem_dq_oe, "R3 hold cycle", {mem_ce_n, mem_dq_oe}, 2'b01);
                we_cnt = 0;
                after_hold = (E_HOLD == 1);
            end
            if (!mem_oe_n) begin
                oe_cnt++;
                oe_hi = 0;
                chk(mem_we_n && !mem_dq_oe, "R4 read strobes", {mem_we_n, mem_dq_oe}, 2'b10);
            end else begin
                if (!oe_prev) begin
                    chk(oe_cnt == E_RD, "R4 read access length", oe_cnt, E_RD);
                    oe_cnt = 0;
                end
                oe_hi++;
            end
            if (mem_dq_oe && !dq_prev)
                chk(oe_hi >= E_HZ + 1, "R5 turnaround", oe_hi, E_HZ + 1);
            if (rsp_valid) begin
                chk(!rsp_prev, "R6 single pulse", rsp_prev, 0);
                if (sb.size() == 0) begin
                    chk(0, "R7 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.rd) chk(rsp_rdata == e.d, "R4 read data", rsp_rdata, e.d);
                end
            end
            we_prev = mem_we_n; oe_prev = mem_oe_n; dq_prev = mem_dq_oe; rsp_prev = rsp_valid;
        end
    end

    task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
        int lat;
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (wr) shadow[a[9:0]] = d;
        e.rd = !wr; e.d = shadow[a[9:0]];
        sb.push_back(e);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        while (!rsp_valid) begin @(negedge clk); lat++; end
        chk(lat == (wr ? E_WLAT : E_RLAT), "R8 access latency", lat, wr ? E_WLAT : E_RLAT);
    endtask

    // store with a second request held up while busy (R7)
    task automatic do_busy_write(input logic [14:0] a, input logic [7:0] d,
                                 input logic [14:0] ga, input logic [7:0] gd);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        shadow[a[9:0]] = d;
        e.rd = 0; e.d = d;
        sb.push_back(e);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        chk(!req_ready, "R7 busy after accept", req_ready, 0);
        req_addr = ga; req_wdata = gd;
        @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        while (!rsp_valid) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 strobes in reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        chk(req_ready && !rsp_valid, "R1 handshake in reset", {req_ready, rsp_valid}, 2'b10);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid,
            "R1 idle after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid},
            6'b111010);

        do_op(1, 15'h0010, 8'h00);
        do_op(1, 15'h0011, 8'hFF);
        do_op(1, 15'h0012, 8'hA5);
        do_op(1, 15'h7C13, 8'h5A);          // upper address bits set
        do_op(0, 15'h0012, 8'h00);
        do_op(0, 15'h0010, 8'h00);
        do_op(0, 15'h0011, 8'h00);
        do_op(0, 15'h7C13, 8'h00);
        for (int i = 0; i < 8; i++) do_op(1, 15'(16'h0100 + i), 8'(8'h11 * i + 3));
        for (int i = 7; i >= 0; i--) do_op(0, 15'(16'h0100 + i), 8'h00);
        // read immediately followed by write: turnaround (R5)
        do_op(1, 15'h0200, 8'h3C);
        do_op(0, 15'h0200, 8'h00);
        do_op(1, 15'h0201, 8'hC3);
        // read data held across a store (R6)
        chk(rsp_rdata == 8'h3C, "R6 rdata held", rsp_rdata, 8'h3C);
        do_op(0, 15'h0201, 8'h00);
        // ignored request while busy (R7)
        do_op(1, 15'h0300, 8'h77);
        do_busy_write(15'h0301, 8'h99, 15'h0300, 8'h44);
        repeat (3) @(negedge clk);
        do_op(0, 15'h0300, 8'h00);          // still 8'h77
        chk(rsp_rdata == 8'h77, "R7 ignored request left memory", rsp_rdata, 8'h77);
        do_op(0, 15'h0301, 8'h00);
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R6 every request answered", sb.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule